// File: doc/BRIEF.md
# Sticky Peak Level Monitor

This block sits beside a stereo sample stream and keeps a coarse record of how loud each channel has been. Every valid 20-bit two's complement sample is steered by a channel flag to the left or the right tracker. Its magnitude is sorted into one of eight level codes: the six 1 dB-wide bins just under full scale, a code for anything quieter, and a code for clipping.

Each tracker holds the largest code it has seen. The code can only rise until the host reads the status byte, and that read returns both codes to zero. A sample that lands in the same cycle as the read is not dropped: it becomes the first entry of the fresh interval. The host sees both codes packed side by side in one byte. The read strobe comes from the surrounding register interface.

Top module: `peak_level_monitor`

## Requirements
- R1: A valid sample updates only the tracker selected by `smp_right` (1 = right, 0 = left). The other tracker keeps its code.
- R2: Magnitude M is sorted into a code. Code 7 is clipping. Otherwise code 7-n for the smallest n in 1..6 with M >= T(n), and code 0 if M < T(6). T(n) = floor(524287 * Q(n) / 65536), where Q(1..6) = 58409, 52057, 46396, 41350, 36854, 32846, which is 10^(-n/20) in 16-bit fixed point.
- R3: A tracker's code never falls except through a read. It rises to a new sample's code only when that code is larger.
- R4: `rd_clr` high at a clock edge sets both codes to zero, apart from the case in R7. Reset also leaves both codes at zero.
- R5: `status` carries the right code in bits 5:3 and the left code in bits 2:0, with bits 7:6 zero. A sample taken at a clock edge is visible right after that edge. During a read cycle `status` still shows the codes from before the clear.
- R6: M is the absolute value of the sample, and the most negative code 0x80000 saturates to 524287. Clipping (code 7) occurs when M reaches 524287, so both 0x7FFFF and 0x80000 give code 7.
- R7: A valid sample in the same cycle as `rd_clr` leaves its channel holding that sample's code. The other channel goes to zero.
- R8: With `smp_valid` low, `smp_data` and `smp_right` have no effect on either code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_right | input | 1 | Channel flag, 1 selects the right tracker |
| smp_data | input | 20 | Two's complement sample |
| rd_clr | input | 1 | Status byte read, clears both codes |
| status | output | 8 | Packed level codes |

## Verification
The hardest cases to reach are the one-code steps at each threshold edge. A threshold is only seen correctly if a sample one below it, one at it and one above it each start from a cleared tracker. The bench therefore reads the status before every boundary sample, and sweeps every threshold at offsets -1, 0 and +1 in both signs on both channels. A long pseudo-random run then mixes reads, idle strobes and samples so that a sample often shares its cycle with a read, which is the folding case.

// File: rtl/plm_pkg.sv
package plm_pkg;
  typedef logic [2:0] level_t;
  localparam int NUM_BINS = 6;
  localparam int NUM_CH   = 2;
  localparam level_t CLIP_CODE = 3'd7;

  // 10^(-n/20) in 16-bit fixed point, n = 1..6
  function automatic int unsigned bin_ratio_q16(input int n);
    case (n)
      1: return 58409;
      2: return 52057;
      3: return 46396;
      4: return 41350;
      5: return 36854;
      default: return 32846;
    endcase
  endfunction
endpackage

// File: rtl/plm_level_classify.sv
module plm_level_classify
  import plm_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic [SAMPLE_W-1:0] sample,
  output level_t              code,
  output logic                clip
);
  localparam logic [SAMPLE_W-1:0] FULL_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  function automatic logic [SAMPLE_W-1:0] sat_abs(input logic [SAMPLE_W-1:0] s);
    if (s == MOST_NEG) return FULL_POS;
    if (s[SAMPLE_W-1]) return SAMPLE_W'(-s);
    return s;
  endfunction

  function automatic logic [SAMPLE_W-1:0] bin_threshold(input int n);
    logic [63:0] prod;
    prod = 64'(FULL_POS) * 64'(bin_ratio_q16(n));
    return SAMPLE_W'(prod >> 16);
  endfunction

  logic [SAMPLE_W-1:0] mag;
  logic [NUM_BINS-1:0] above;

  assign mag = sat_abs(sample);

  genvar g;
  generate
    for (g = 1; g <= NUM_BINS; g++) begin : g_bin
      localparam logic [SAMPLE_W-1:0] THR = bin_threshold(g);
      assign above[g-1] = (mag >= THR);
    end
  endgenerate

  assign clip = (mag == FULL_POS);
  assign code = clip ? CLIP_CODE : level_t'($countones(above));
endmodule

// File: rtl/plm_peak_hold.sv
module plm_peak_hold
  import plm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  level_t code,
  input  logic   clr,
  output level_t held
);
  logic raise;
  assign raise = upd && (code > held);

  always_ff @(posedge clk) begin
    if (!rst_n)   held <= '0;
    else if (clr) held <= upd ? code : '0;
    else if (raise) held <= code;
  end

  // R3
  no_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> held >= $past(held));
  // R3
  rise_to_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && upd && code > held) |=> held == $past(code));
  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !upd) |=> held == '0);
  // R7
  fold_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && upd) |=> held == $past(code));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> $stable(held));
endmodule

// File: rtl/peak_level_monitor.sv
module peak_level_monitor
  import plm_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic                smp_right,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                rd_clr,
  output logic [7:0]          status
);
  level_t new_code;
  logic   new_clip;
  level_t held [NUM_CH];
  logic   ch_upd [NUM_CH];

  plm_level_classify #(.SAMPLE_W(SAMPLE_W)) u_classify (
    .sample (smp_data),
    .code   (new_code),
    .clip   (new_clip)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      assign ch_upd[c] = smp_valid && (smp_right == (c == 1));
      plm_peak_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (ch_upd[c]),
        .code  (new_code),
        .clr   (rd_clr),
        .held  (held[c])
      );
    end
  endgenerate

  assign status = {2'b00, held[1], held[0]};

  // R6
  clip_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (new_clip && smp_valid && !smp_right) |=> status[2:0] == CLIP_CODE);
  // R1
  right_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && smp_valid && !smp_right) |=> $stable(status[5:3]));
endmodule

// File: tb/peak_level_monitor_bench.sv
module peak_level_monitor_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        smp_valid = 0;
  logic        smp_right = 0;
  logic [19:0] smp_data = '0;
  logic        rd_clr = 0;
  logic [7:0]  status;

  int vectors = 0;
  int miscompares = 0;
  int ml = 0, mr = 0;

  always #4 clk = ~clk;

  peak_level_monitor u_peak_level_monitor (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_right(smp_right),
    .smp_data(smp_data), .rd_clr(rd_clr), .status(status)
  );

  function automatic longint q16(input int n);
    case (n)
      1: return 58409; 2: return 52057; 3: return 46396;
      4: return 41350; 5: return 36854; default: return 32846;
    endcase
  endfunction

  function automatic int thr(input int n);
    return int'((longint'(524287) * q16(n)) / 65536);
  endfunction

  function automatic int exp_code(input logic [19:0] s);
    int m;
    if (s == 20'h80000) return 7;
    m = s[19] ? (1 << 20) - int'(s) : int'(s);
    if (m >= 524287) return 7;
    for (int n = 1; n <= 6; n++) if (m >= thr(n)) return 7 - n;
    return 0;
  endfunction

  task automatic check(input string tag);
    logic [7:0] exp;
    exp = {2'b00, 3'(mr), 3'(ml)};
    vectors++;
    if (status !== exp) begin
      miscompares++;
      $display("FAIL %s: status=%h expected=%h", tag, status, exp);
    end
  endtask

  task automatic step(input bit v, input bit r, input logic [19:0] d,
                      input bit rd, input string tag);
    int c;
    @(negedge clk);
    check(tag);
    smp_valid = v; smp_right = r; smp_data = d; rd_clr = rd;
    c = exp_code(d);
    if (rd) begin
      ml = (v && !r) ? c : 0;
      mr = (v && r) ? c : 0;
    end else if (v) begin
      if (r && c > mr) mr = c;
      if (!r && c > ml) ml = c;
    end
    @(posedge clk);
  endtask

  initial begin
    #(8 * 190000);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [19:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R4 reset");
    // R2 R5 threshold sweep, each from a cleared tracker
    for (int n = 1; n <= 6; n++)
      for (int off = -1; off <= 1; off++)
        for (int sg = 0; sg < 2; sg++)
          for (int ch = 0; ch < 2; ch++) begin
            int m;
            logic [19:0] d;
            m = thr(n) + off;
            d = sg ? 20'((1 << 20) - m) : 20'(m);
            step(0, 0, 20'h0, 1, "R4 clear");
            step(1, ch[0], d, 0, "R2 threshold");
          end
    // R6 clip and saturation
    step(0, 0, 20'h0, 1, "R4 clear");
    step(1, 0, 20'h80000, 0, "R6 most negative");
    step(1, 1, 20'h7FFFF, 0, "R6 max positive");
    step(0, 0, 20'h0, 1, "R6 clip seen");
    step(1, 0, 20'h7FFFE, 0, "R6 just under clip");
    step(1, 1, 20'h80001, 0, "R6 negative just under clip");
    // R3 no decrease
    step(1, 0, 20'h00001, 0, "R3 after high");
    step(1, 0, 20'hFFFFF, 0, "R3 small negative");
    // R8 invalid samples ignored
    step(0, 0, 20'h7FFFF, 0, "R3 hold");
    step(0, 1, 20'h80000, 0, "R8 invalid left");
    step(0, 0, 20'h0, 1, "R8 invalid right");
    step(0, 1, 20'h7FFFF, 0, "R4 cleared");
    // R7 fold on read, R1 isolation
    step(1, 1, 20'h7FFFF, 1, "R8 still zero");
    step(1, 0, 20'h40000, 0, "R7 fold right");
    step(0, 0, 20'h0, 0, "R1 left only");
    lfsr = 20'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[18:0], lfsr[19] ^ lfsr[16]};
      step(lfsr[3], lfsr[7], {lfsr[0], lfsr[19:1]}, (lfsr[11:9] == 3'b000),
           "R1 R3 R7 random");
    end
    step(0, 0, 20'h0, 0, "R5 final");
    @(negedge clk);
    check("R5 final");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule